// File: doc/BRIEF.md
# Chip-Select Bank Address Decoder

This block turns a CPU address into one of eight chip selects for an external bus. Each bank has one configuration word. The word holds a window base, an inverted window mask and an enable. Both the base and the mask work in 128 KiB units. For every access strobe, the block compares the upper address bits with all eight windows at once. It then drives at most one chip select, registered one cycle later. When nothing matches, it raises a decode-error flag instead.

A boot strap, sampled only while reset is held, exchanges chip selects 0 and 1. This lets the board boot from either device. Banks 0 and 1 have two special behaviours:

- They cannot be switched off with the enable bit alone.
- A configuration word of zero in either of them claims the whole address space.

Firmware therefore parks an unused bank 0 or bank 1 by writing all ones to its word.

Top module: `csdec_top`

## Requirements
- R1: After reset the bank 0 word reads 0x00000001 when the strap was low during reset, or 0x00000000 when it was high. Every other bank word reads 0x00000000.
- R2: Bank n's word sits at register offset 0x100 + 0x10*n. Bit 16 always reads 0. A read of any other offset returns 0, and a write to any other offset changes no bank word.
- R3: Bits [31:17] hold the base and bits [15:1] hold the mask. A bank matches when, for every mask bit k that is 1, address bit k+16 equals base bit k+16.
- R4: Bit 0 is the enable. A bank whose enable is 0 never matches, except as stated in R5.
- R5: A bank 0 or bank 1 word equal to zero matches every address, whatever its enable.
- R6: A bank 0 or bank 1 word written with all ones matches only addresses 0xFFFE0000 to 0xFFFFFFFF.
- R7: When several banks match, the lowest-numbered bank wins.
- R8: A strobed access that matches no bank raises dec_err in the following cycle, with all chip selects low.
- R9: Outputs follow a strobe by exactly one cycle. At most one chip select is high at a time. A cycle with no strobe is followed by a cycle with every output low.
- R10: If the strap was high during reset, bank 0 drives cs_o[1] and bank 1 drives cs_o[0]. Changes on the strap after reset have no effect.
- R11: A register write changes decoding starting with strobes in the cycle after the write. A strobe in the same cycle as the write uses the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| boot_swap | input | 1 | Boot strap that exchanges chip selects 0 and 1, sampled while in reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access address |
| cs_o | output | 8 | One-hot chip selects, registered |
| dec_err | output | 1 | Registered flag: no bank matched the access |

## Verification
The assertions take for granted that the clock keeps running while rst_n is low, because the strap and the bank 0 enable are captured on clock edges during reset. They also take for granted that the strap is only meaningful in that window. The stimulus holds reset for several clocks with the strap at a fixed level. It changes the strap only after release, to show that the change has no effect. All inputs change half a cycle away from the sampling edge, so the one-cycle output latency is well defined.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  // Lowest address bit that takes part in window comparison (128 KiB units).
  localparam int WIN_LSB   = 17;
  localparam int WORD_W    = 32;
  localparam int FIELD_W   = WORD_W - WIN_LSB;   // base/mask field width
  localparam int MASK_LSB  = WIN_LSB - 16;       // mask field lowest bit
  localparam int HOLE_BIT  = 16;                 // always-zero bit
  localparam logic [WORD_W-1:0] WRITE_KEEP = ~(WORD_W'(1) << HOLE_BIT);

  typedef logic [WORD_W-1:0] cfg_word_t;
endpackage

// File: rtl/csdec_bankregs.sv
module csdec_bankregs
  import csdec_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int RA_W   = 12,
  parameter int OFF    = 'h100,
  parameter int STRIDE = 'h10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          boot_swap,
  input  logic                          reg_we,
  input  logic [RA_W-1:0]               reg_addr,
  input  logic [WORD_W-1:0]             reg_wdata,
  output logic [WORD_W-1:0]             reg_rdata,
  output logic [NBANK-1:0][WORD_W-1:0]  cfg,
  output logic                          swap
);

  logic swap_q;
  logic [NBANK-1:0] wsel;

  // Strap capture: loaded on every edge while reset is held, frozen after.
  always_ff @(posedge clk) begin
    if (!rst_n) swap_q <= boot_swap;
  end
  assign swap = swap_q;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam logic [RA_W-1:0] MY_OFF = RA_W'(OFF + STRIDE * i);
    logic [WORD_W-1:1] hi_q, hi_d;
    logic              en_q, en_d;
    logic              ld;

    assign wsel[i] = reg_we && (reg_addr == MY_OFF);
    assign ld      = wsel[i];

    always_comb begin
      hi_d = hi_q;
      en_d = en_q;
      if (ld) begin
        hi_d = reg_wdata[WORD_W-1:1] & WRITE_KEEP[WORD_W-1:1];
        en_d = reg_wdata[0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_q <= '0;
      else if (ld) hi_q <= hi_d;
    end

    if (i == 0) begin : g_boot_en
      // Reset value depends on the strap, so it is loaded on clock edges in reset.
      always_ff @(posedge clk) begin
        if (!rst_n) en_q <= ~boot_swap;
        else if (ld) en_q <= en_d;
      end
    end else begin : g_plain_en
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else if (ld) en_q <= en_d;
      end
    end

    assign cfg[i] = {hi_q, en_q};
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (reg_addr == RA_W'(OFF + STRIDE * i)) reg_rdata = cfg[i];
    end
  end

  // R10: strap state never moves once reset is released.
  assert_strap_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(swap_q));

  // R2: at most one bank word is written per cycle.
  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel));

endmodule

// File: rtl/csdec_window.sv
module csdec_window
  import csdec_pkg::*;
#(
  parameter int NBANK = 8
) (
  input  logic [NBANK-1:0][WORD_W-1:0] cfg,
  input  logic [WORD_W-1:0]            acc_addr,
  output logic [NBANK-1:0]             hit
);

  for (genvar i = 0; i < NBANK; i++) begin : g_win
    logic [FIELD_W-1:0] base_f, mask_f, diff;
    logic               en, in_win, all_zero;

    assign base_f   = cfg[i][WORD_W-1:WIN_LSB];
    assign mask_f   = cfg[i][MASK_LSB+FIELD_W-1:MASK_LSB];
    assign en       = cfg[i][0];
    assign diff     = (acc_addr[WORD_W-1:WIN_LSB] ^ base_f) & mask_f;
    assign in_win   = (diff == '0);
    assign all_zero = (cfg[i] == '0);

    if (i < 2) begin : g_boot_bank
      // A cleared word in the two boot banks claims every address.
      assign hit[i] = all_zero | (en & in_win);
    end else begin : g_std_bank
      assign hit[i] = en & in_win;
    end
  end

endmodule

// File: rtl/csdec_select.sv
module csdec_select
  import csdec_pkg::*;
#(
  parameter int NBANK = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swap,
  input  logic             acc_valid,
  input  logic [NBANK-1:0] hit,
  output logic [NBANK-1:0] cs_o,
  output logic             dec_err
);

  localparam int IDX_W = $clog2(NBANK);

  logic [IDX_W-1:0] win;
  logic             found;
  logic [NBANK-1:0] onehot, routed, cs_d, cs_q;
  logic             err_d, err_q;

  // Lowest index wins.
  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int i = 0; i < NBANK; i++) begin
      if (hit[i] && !found) begin
        win   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    onehot = '0;
    if (found) onehot[win] = 1'b1;
    routed = onehot;
    if (swap) begin
      routed[0] = onehot[1];
      routed[1] = onehot[0];
    end
    cs_d  = acc_valid ? routed : '0;
    err_d = acc_valid & ~found;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= '0;
      err_q <= 1'b0;
    end else begin
      cs_q  <= cs_d;
      err_q <= err_d;
    end
  end

  assign cs_o    = cs_q;
  assign dec_err = err_q;

  assert_onehot_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (cs_o == '0 && !dec_err));

  assert_err_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> (cs_o == '0));

  assert_strobe_answered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (cs_o != '0 || dec_err));

  assert_miss_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit == '0) |=> dec_err);

endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int RA_W   = 12,
  parameter int OFF    = 'h100,
  parameter int STRIDE = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_swap,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  output logic [NBANK-1:0]  cs_o,
  output logic              dec_err
);

  logic [NBANK-1:0][WORD_W-1:0] cfg;
  logic                         swap;
  logic [NBANK-1:0]             hit;

  csdec_bankregs #(.NBANK(NBANK), .RA_W(RA_W), .OFF(OFF), .STRIDE(STRIDE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_swap (boot_swap),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg       (cfg),
    .swap      (swap)
  );

  csdec_window #(.NBANK(NBANK)) u_win (
    .cfg      (cfg),
    .acc_addr (acc_addr),
    .hit      (hit)
  );

  csdec_select #(.NBANK(NBANK)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap      (swap),
    .acc_valid (acc_valid),
    .hit       (hit),
    .cs_o      (cs_o),
    .dec_err   (dec_err)
  );

endmodule

// File: tb/sim_csdec_top.sv
module sim_csdec_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        boot_swap;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [7:0]  cs_o;
  logic        dec_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  logic [31:0] mreg [8];
  bit          mswap;

  always #2 clk = ~clk;

  csdec_top u0 (
    .clk(clk), .rst_n(rst_n), .boot_swap(boot_swap),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .cs_o(cs_o), .dec_err(dec_err)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung");
      report();
    end
  end

  function automatic void model_decode(input logic [31:0] a, output logic [7:0] cs, output bit err);
    int w = -1;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v = mreg[i];
      bit h;
      h = (v[0] == 1'b1) && ((((a[31:17] ^ v[31:17]) & v[15:1])) == 15'd0);
      if (i < 2 && v == 32'd0) h = 1;
      if (h && w < 0) w = i;
    end
    cs = 8'd0;
    err = (w < 0);
    if (w >= 0) begin
      int p = w;
      if (mswap && w < 2) p = 1 - w;
      cs[p] = 1'b1;
    end
  endfunction

  task automatic do_reset(input bit s);
    rst_n = 1'b0;
    boot_swap = s;
    reg_we = 0; reg_addr = '0; reg_wdata = '0; acc_valid = 0; acc_addr = '0;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 8; i++) mreg[i] = 32'd0;
    mreg[0] = s ? 32'd0 : 32'd1;
    mswap = s;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Called at a negedge: drives one cycle, checks outputs at the next negedge.
  task automatic cyc(input bit v, input logic [31:0] a, input bit we,
                     input logic [11:0] wa, input logic [31:0] wd, input string tag);
    logic [7:0] ecs;
    bit eerr;
    acc_valid = v; acc_addr = a; reg_we = we; reg_addr = wa; reg_wdata = wd;
    model_decode(a, ecs, eerr);
    if (!v) begin ecs = 8'd0; eerr = 0; end
    @(posedge clk);
    if (we) begin
      for (int i = 0; i < 8; i++)
        if (wa == 12'(32'h100 + 32'h10 * i)) mreg[i] = wd & 32'hFFFE_FFFF;
    end
    @(negedge clk);
    acc_valid = 0; reg_we = 0;
    checks++;
    if (cs_o !== ecs || dec_err !== eerr) begin
      errors++;
      $display("FAIL %s addr=%h: cs=%b err=%b expected cs=%b err=%b", tag, a, cs_o, dec_err, ecs, eerr);
    end
  endtask

  task automatic wr(input logic [11:0] wa, input logic [31:0] wd, input string tag);
    cyc(0, 32'd0, 1, wa, wd, tag);
  endtask

  task automatic acc(input logic [31:0] a, input string tag);
    cyc(1, a, 0, 12'd0, 32'd0, tag);
  endtask

  task automatic rd(input logic [11:0] wa, input logic [31:0] exp, input string tag);
    reg_we = 0;
    reg_addr = wa;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read %h: got %h expected %h", tag, wa, reg_rdata, exp);
    end
  endtask

  initial begin
    do_reset(0);
    // R1 reset values
    rd(12'h100, 32'h0000_0001, "R1");
    for (int i = 1; i < 8; i++) rd(12'(32'h100 + 32'h10 * i), 32'h0, "R1");
    acc(32'h1234_5678, "R1");
    cyc(0, 32'h0, 0, 12'h0, 32'h0, "R9");

    // Program windows
    wr(12'h100, 32'hFFFF_FFFF, "R6");
    wr(12'h110, 32'hFFFF_FFFF, "R6");
    wr(12'h120, 32'h0000_FF01, "R3");
    wr(12'h130, 32'h0200_FE01, "R3");
    wr(12'h140, 32'h0400_FC00, "R4");
    wr(12'h150, 32'h0801_FFFF, "R2");
    wr(12'h160, 32'h0000_FF01, "R7");
    rd(12'h100, 32'hFFFE_FFFF, "R2");
    rd(12'h150, 32'h0800_FFFF, "R2");
    wr(12'h104, 32'hFFFF_FFFF, "R2");
    rd(12'h104, 32'h0, "R2");
    rd(12'h170, 32'h0, "R2");
    rd(12'h000, 32'h0, "R2");

    acc(32'h0012_3456, "R7");
    acc(32'h0300_0000, "R3");
    acc(32'h0200_0000, "R3");
    acc(32'h0500_0000, "R4");
    acc(32'h0801_FFFF, "R3");
    acc(32'h0802_0000, "R8");
    acc(32'hFFFF_0000, "R6");
    acc(32'hFFFD_FFFF, "R6");
    acc(32'h4000_0000, "R8");
    cyc(0, 32'h0012_3456, 0, 12'h0, 32'h0, "R9");

    // R11: write and strobe in the same cycle use the old word
    cyc(1, 32'h4000_0000, 1, 12'h170, 32'h4000_C001, "R11");
    acc(32'h4000_0000, "R11");

    // R5: zero word in bank 1 claims everything not taken by bank 0
    wr(12'h110, 32'h0, "R5");
    acc(32'h0300_0000, "R5");
    acc(32'h9000_0000, "R5");
    acc(32'hFFFF_FFFF, "R7");
    wr(12'h110, 32'h0000_0000 | 32'h0, "R5");
    wr(12'h100, 32'h0000_0000, "R5");
    acc(32'hFFFF_FFFF, "R5");

    // R10: boot swap
    do_reset(1);
    rd(12'h100, 32'h0, "R1");
    acc(32'h0000_0010, "R10");
    wr(12'h100, 32'hFFFF_FFFF, "R10");
    wr(12'h110, 32'h0000_FF01, "R10");
    acc(32'h0000_0010, "R10");
    acc(32'hFFFE_0000, "R10");
    boot_swap = 0;
    acc(32'h0000_0010, "R10");
    acc(32'h2000_0000, "R8");

    done = 1;
    report();
  end
endmodule